// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog peripheral behind an APB slave port. Software loads a reload value, enables the down counter, and must service the timer before it runs out. When the count is spent the block raises an interrupt and starts a fresh period from the reload value. If the next period also runs out before software has cleared the interrupt, and resets are enabled, the block asserts a reset output that stays high until the block itself is reset.

The counter does not step on every bus clock. It uses a second clock that is synchronous with the bus clock and edge-aligned to it, and whose frequency is no higher. That clock is given to the block as a per-bus-cycle strobe (`cnt_tick`, high on bus edges that line up with a counter-clock rising edge) and is qualified by a clock enable (`cnt_en`). The count moves only when both are high. A protection register must hold a magic key before any other register accepts a write, so stray software stores cannot stop the watchdog.

Top module: `wdt_lockable`

## Requirements
- R1: After reset the reload and count registers read 0xFFFFFFFF, the control register reads 0, the protection register reads 0 (writable), and `irq_o` and `rst_o` are low.
- R2: Register offsets: reload 0x000 (read/write), count 0x004 (read only), control 0x008 (bit 0 runs the counter and unmasks the interrupt, bit 1 allows the reset output), interrupt clear 0x00C (write only), raw interrupt 0x010 (bit 0), masked interrupt 0x014 (bit 0), protection 0xC00. Reads of any other offset return 0.
- R3: Writing 0x1ACCE551 to the protection register makes the other registers writable; writing any other value protects them. The protection register reads 1 when protected and 0 when writable.
- R4: While protected, writes to the reload, control and interrupt-clear registers have no effect on any register, the count or the interrupt.
- R5: A write to the reload register sets the count to the written value on the same clock edge.
- R6: The count drops by exactly one on each bus clock edge where `cnt_tick`, `cnt_en` and control bit 0 are all high, and holds otherwise; with `cnt_en` high on alternate ticks it drops once per two ticks.
- R7: An enabled step taken while the count is 0 sets the raw interrupt and reloads the count from the reload register instead of wrapping.
- R8: A write to the interrupt-clear register clears the raw interrupt and reloads the count from the reload register.
- R9: An enabled step taken at count 0 while the raw interrupt is already set and control bit 1 is high asserts `rst_o`; it then stays high until `presetn` is driven low. With bit 1 low no reset is produced.
- R10: `irq_o` and the masked status bit equal the raw interrupt ANDed with control bit 0.
- R11: Writes to the count register are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock; clocks all state |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| cnt_tick | input | 1 | High on bus edges aligned with a counter-clock rising edge |
| cnt_en | input | 1 | Counter clock enable |
| irq_o | output | 1 | Masked timeout interrupt |
| rst_o | output | 1 | Sticky watchdog reset request |

## Verification
The bench builds the block with its default 32-bit counter, and keeps every period short by loading a reload value of 5, so the interrupt, the reload and the reset all arrive within a few dozen ticks. Stepping is exercised with the tick alone, the enable alone, both held high and the enable pulsed on alternate ticks, which makes the once-per-two-ticks rate visible in the count readback. Protected writes are tried on every writable register and then observed through readback and the interrupt pin.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned OFS_W  = 12;

    localparam logic [OFS_W-1:0] OFS_RELOAD = 12'h000;
    localparam logic [OFS_W-1:0] OFS_COUNT  = 12'h004;
    localparam logic [OFS_W-1:0] OFS_CTRL   = 12'h008;
    localparam logic [OFS_W-1:0] OFS_ICLR   = 12'h00C;
    localparam logic [OFS_W-1:0] OFS_RAW    = 12'h010;
    localparam logic [OFS_W-1:0] OFS_MASKED = 12'h014;
    localparam logic [OFS_W-1:0] OFS_GUARD  = 12'hC00;

    localparam logic [BUS_W-1:0] GUARD_KEY  = 32'h1ACC_E551;

    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_RST_BIT = 1;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [OFS_W-1:0] paddr,
    input  logic [BUS_W-1:0] pwdata,
    output logic [BUS_W-1:0] prdata,
    input  logic [CNT_W-1:0] count,
    input  logic             raw_irq,
    output logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] load_now,
    output logic             load_strobe,
    output logic             clr_strobe,
    output logic             run_en,
    output logic             rst_allow,
    output logic             guarded
);

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic             run;
        logic             rst_ok;
        logic             guard;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic wr_acc;
    logic wr_open;
    logic rd_acc;

    always_comb begin
        st_d        = st_q;
        wr_acc      = psel && penable && pwrite;
        wr_open     = wr_acc && !st_q.guard;
        load_strobe = 1'b0;
        clr_strobe  = 1'b0;
        load_now    = st_q.reload;

        if (wr_acc && (paddr == OFS_GUARD)) begin
            st_d.guard = (pwdata != GUARD_KEY);
        end

        if (wr_open) begin
            case (paddr)
                OFS_RELOAD: begin
                    st_d.reload = pwdata[CNT_W-1:0];
                    load_now    = pwdata[CNT_W-1:0];
                    load_strobe = 1'b1;
                end
                OFS_CTRL: begin
                    st_d.run    = pwdata[CTRL_RUN_BIT];
                    st_d.rst_ok = pwdata[CTRL_RST_BIT];
                end
                OFS_ICLR: begin
                    load_strobe = 1'b1;
                    clr_strobe  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.reload <= '1;
            st_q.run    <= 1'b0;
            st_q.rst_ok <= 1'b0;
            st_q.guard  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_acc = psel && !pwrite;
        prdata = '0;
        if (rd_acc) begin
            case (paddr)
                OFS_RELOAD: prdata[CNT_W-1:0] = st_q.reload;
                OFS_COUNT:  prdata[CNT_W-1:0] = count;
                OFS_CTRL: begin
                    prdata[CTRL_RUN_BIT] = st_q.run;
                    prdata[CTRL_RST_BIT] = st_q.rst_ok;
                end
                OFS_RAW:    prdata[0] = raw_irq;
                OFS_MASKED: prdata[0] = raw_irq && st_q.run;
                OFS_GUARD:  prdata[0] = st_q.guard;
                default:    prdata = '0;
            endcase
        end
    end

    assign reload_val = st_q.reload;
    assign run_en     = st_q.run;
    assign rst_allow  = st_q.rst_ok;
    assign guarded    = st_q.guard;

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             run_en,
    input  logic             rst_allow,
    input  logic             load_strobe,
    input  logic [CNT_W-1:0] load_now,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             clr_strobe,
    output logic [CNT_W-1:0] count,
    output logic             raw_irq,
    output logic             rst_req
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             rst;
    } core_state_t;

    core_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (load_strobe) begin
            cs_d.cnt = load_now;
        end else if (step && run_en) begin
            if (cs_q.cnt == '0) begin
                cs_d.cnt = reload_val;
                cs_d.irq = 1'b1;
                if (cs_q.irq && rst_allow) begin
                    cs_d.rst = 1'b1;
                end
            end else begin
                cs_d.cnt = cs_q.cnt - 1'b1;
            end
        end
        if (clr_strobe) begin
            cs_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q.cnt <= '1;
            cs_q.irq <= 1'b0;
            cs_q.rst <= 1'b0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign count   = cs_q.cnt;
    assign raw_irq = cs_q.irq;
    assign rst_req = cs_q.rst;

endmodule

// File: rtl/wdt_lockable.sv
module wdt_lockable
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             pclk,
    input  logic             presetn,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [11:0]      paddr,
    input  logic [31:0]      pwdata,
    output logic [31:0]      prdata,
    input  logic             cnt_tick,
    input  logic             cnt_en,
    output logic             irq_o,
    output logic             rst_o
);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] load_now;
    logic             load_strobe;
    logic             clr_strobe;
    logic             run_en;
    logic             rst_allow;
    logic             guarded;
    logic             raw_irq;
    logic             step;

    assign step = cnt_tick && cnt_en;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (pclk),
        .rst_n       (presetn),
        .psel        (psel),
        .penable     (penable),
        .pwrite      (pwrite),
        .paddr       (paddr),
        .pwdata      (pwdata),
        .prdata      (prdata),
        .count       (count),
        .raw_irq     (raw_irq),
        .reload_val  (reload_val),
        .load_now    (load_now),
        .load_strobe (load_strobe),
        .clr_strobe  (clr_strobe),
        .run_en      (run_en),
        .rst_allow   (rst_allow),
        .guarded     (guarded)
    );

    wdt_core #(.CNT_W(CNT_W)) u_core (
        .clk         (pclk),
        .rst_n       (presetn),
        .step        (step),
        .run_en      (run_en),
        .rst_allow   (rst_allow),
        .load_strobe (load_strobe),
        .load_now    (load_now),
        .reload_val  (reload_val),
        .clr_strobe  (clr_strobe),
        .count       (count),
        .raw_irq     (raw_irq),
        .rst_req     (rst_o)
    );

    assign irq_o = raw_irq && run_en;

endmodule

// File: rtl/wdt_lockable_chk.sv
module wdt_lockable_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             psel,
    input logic             penable,
    input logic             pwrite,
    input logic [11:0]      paddr,
    input logic             step,
    input logic             run_en,
    input logic             load_strobe,
    input logic             clr_strobe,
    input logic             guarded,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload_val,
    input logic             raw_irq,
    input logic             rst_o
);

    // R9
    rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |=> rst_o);

    // R9
    rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> $past(raw_irq));

    // R7
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_irq) |-> ($past(count) == '0));

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && run_en && !load_strobe && count != '0) |=> (count == $past(count) - 1'b1));

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(step && run_en) && !load_strobe) |=> $stable(count));

    // R4
    guarded_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (guarded && psel && penable && pwrite && paddr == 12'h000) |=> $stable(reload_val));

    // R8
    clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_strobe |=> !raw_irq);

endmodule

bind wdt_lockable wdt_lockable_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (pclk),
    .rst_n       (presetn),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .step        (step),
    .run_en      (run_en),
    .load_strobe (load_strobe),
    .clr_strobe  (clr_strobe),
    .guarded     (guarded),
    .count       (count),
    .reload_val  (reload_val),
    .raw_irq     (raw_irq),
    .rst_o       (rst_o)
);

// File: tb/wdt_lockable_test.sv
`timescale 1ns/1ps
module wdt_lockable_test;

    typedef struct {
        logic [11:0] addr;
        logic [31:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        cnt_tick = 1'b0;
    logic        cnt_en = 1'b0;
    logic        irq_o;
    logic        rst_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    wdt_lockable uut (
        .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .cnt_tick(cnt_tick), .cnt_en(cnt_en), .irq_o(irq_o), .rst_o(rst_o)
    );

    // monitor: pops one expectation per read access phase
    always @(negedge clk) begin
        if (psel && penable && !pwrite) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard empty at read of %h: actual=%h expected=none", paddr, prdata);
            end else begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (prdata !== e.val || paddr !== e.addr) begin
                    bad++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", e.tag, e.addr, prdata, e.val);
                end
            end
        end
    end

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] v);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = v; penable = 1'b0;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] v, input string tag);
        exp_t e;
        e.addr = a; e.val = v; e.tag = tag;
        sb.push_back(e);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic chk_pin(input logic act_sel, input logic exp_v, input string tag);
        logic act;
        @(negedge clk);
        act = act_sel ? rst_o : irq_o;
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp_v);
        end
        @(posedge clk); #1;
    endtask

    // mode: 0 enable low, 1 enable high, 2 enable on even iterations only
    task automatic ticks(input int n, input logic t, input int mode);
        for (int i = 0; i < n; i++) begin
            cnt_tick = t;
            cnt_en = (mode == 1) ? 1'b1 : ((mode == 2) ? ((i % 2) == 0) : 1'b0);
            @(posedge clk); #1;
        end
        cnt_tick = 1'b0; cnt_en = 1'b0;
    endtask

    task automatic do_reset();
        presetn = 1'b0;
        repeat (2) @(posedge clk);
        #1 presetn = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic wrap_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            wrap_up();
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        expect_rd(12'h000, 32'hFFFF_FFFF, "R1 reload");
        expect_rd(12'h004, 32'hFFFF_FFFF, "R1 count");
        expect_rd(12'h008, 32'h0, "R1 ctrl");
        expect_rd(12'hC00, 32'h0, "R1 guard");
        chk_pin(1'b0, 1'b0, "R1 irq_o");
        chk_pin(1'b1, 1'b0, "R1 rst_o");
        // R2 unmapped offset
        expect_rd(12'h018, 32'h0, "R2 unmapped");

        // R5 reload write sets count
        apb_wr(12'h000, 32'd5);
        expect_rd(12'h000, 32'd5, "R2 reload readback");
        expect_rd(12'h004, 32'd5, "R5 count after reload write");
        // R11 count is read only
        apb_wr(12'h004, 32'h77);
        expect_rd(12'h004, 32'd5, "R11 count write ignored");

        // R6 stepping rules
        ticks(4, 1'b1, 0);
        expect_rd(12'h004, 32'd5, "R6 counting disabled in ctrl");
        apb_wr(12'h008, 32'h1);
        expect_rd(12'h008, 32'h1, "R2 ctrl readback");
        ticks(4, 1'b1, 0);
        expect_rd(12'h004, 32'd5, "R6 tick without enable");
        ticks(3, 1'b0, 1);
        expect_rd(12'h004, 32'd5, "R6 enable without tick");
        ticks(4, 1'b1, 2);
        expect_rd(12'h004, 32'd3, "R6 alternate enable halves rate");
        ticks(3, 1'b1, 1);
        expect_rd(12'h004, 32'd0, "R6 count reaches zero");
        expect_rd(12'h010, 32'h0, "R7 no irq at zero yet");
        // R7 expiry
        ticks(1, 1'b1, 1);
        expect_rd(12'h010, 32'h1, "R7 raw irq set");
        expect_rd(12'h004, 32'd5, "R7 count reloaded");
        chk_pin(1'b0, 1'b1, "R10 irq_o with run set");
        expect_rd(12'h014, 32'h1, "R10 masked set");
        // R10 masking
        apb_wr(12'h008, 32'h0);
        chk_pin(1'b0, 1'b0, "R10 irq_o masked");
        expect_rd(12'h014, 32'h0, "R10 masked clear");
        expect_rd(12'h010, 32'h1, "R10 raw stays");
        apb_wr(12'h008, 32'h1);
        // R8 clear
        ticks(2, 1'b1, 1);
        apb_wr(12'h00C, 32'h0);
        expect_rd(12'h010, 32'h0, "R8 raw cleared");
        expect_rd(12'h004, 32'd5, "R8 count reloaded");

        // R3 / R4 protection
        apb_wr(12'hC00, 32'h0);
        expect_rd(12'hC00, 32'h1, "R3 guard set by other value");
        apb_wr(12'h000, 32'd9);
        expect_rd(12'h000, 32'd5, "R4 reload write ignored");
        expect_rd(12'h004, 32'd5, "R4 count untouched");
        apb_wr(12'h008, 32'h0);
        expect_rd(12'h008, 32'h1, "R4 ctrl write ignored");
        ticks(6, 1'b1, 1);
        expect_rd(12'h010, 32'h1, "R7 irq under guard");
        apb_wr(12'h00C, 32'h0);
        expect_rd(12'h010, 32'h1, "R4 clear ignored");
        chk_pin(1'b0, 1'b1, "R4 irq_o still high");
        apb_wr(12'hC00, 32'h1ACC_E551);
        expect_rd(12'hC00, 32'h0, "R3 key opens");

        // R9 reset disabled, then enabled
        ticks(6, 1'b1, 1);
        chk_pin(1'b1, 1'b0, "R9 no reset without bit1");
        expect_rd(12'h004, 32'd5, "R7 second reload");
        apb_wr(12'h008, 32'h3);
        ticks(5, 1'b1, 1);
        chk_pin(1'b1, 1'b0, "R9 no reset before expiry");
        ticks(1, 1'b1, 1);
        chk_pin(1'b1, 1'b1, "R9 reset asserted");
        apb_wr(12'h00C, 32'h0);
        chk_pin(1'b1, 1'b1, "R9 reset sticky after clear");
        do_reset();
        chk_pin(1'b1, 1'b0, "R9 reset released by presetn");
        expect_rd(12'h004, 32'hFFFF_FFFF, "R1 count after second reset");

        repeat (3) @(posedge clk);
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
        end
        finished = 1;
        wrap_up();
    end

endmodule